// File: doc/BRIEF.md
# PE weight-vector index walker

This block takes one mapping parameter set and, from it, walks all the processing elements of a two-dimensional array that is ARR_H rows tall and ARR_W columns wide. For each element it gives the row index and the column index of the weight vector that element has to load. The element with array coordinates (ah, aw) reads weight-vector row `row_base + floor(aw / grp_row)`. It reads column `col_base + row_stride*ah + col_stride*(aw mod grp_col)`. Both indices are reduced modulo 2^IDX_W.

The block emits one tuple (ah, aw, row, col) per handshake on a valid/ready output. After the tuple for the last element has been taken, `done` pulses for one cycle. A new parameter set is taken in only while the block is idle. No dividers are used: the floor and the modulo come from two running counters. One counter wraps at the row group size and moves the row forward. The other wraps at the replication period and restarts the column offset.

Top module: `pe_map_gen`

## Requirements
- R1: While reset is held and just after it is released, `out_valid` and `done` are 0 and `cfg_ready` is 1.
- R2: `cfg_ready` is 1 exactly when no walk is in progress. A parameter set is accepted on a clock edge where both `cfg_valid` and `cfg_ready` are 1. A `cfg_valid` asserted during a walk is ignored, and the tuples already being emitted keep their original parameters.
- R3: A walk emits exactly ARR_H*ARR_W tuples in row-major order. `aw` runs from 0 to ARR_W-1 fastest, and `ah` runs from 0 to ARR_H-1 outer.
- R4: `out_row` equals (row_base + floor(aw / grp_row)) mod 2^IDX_W. This holds for any `grp_row`, including values that do not divide ARR_W.
- R5: `out_col` equals (col_base + row_stride*ah + col_stride*(aw mod grp_col)) mod 2^IDX_W.
- R6: A `grp_row` or `grp_col` value of 0 behaves exactly like a value of 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, all tuple outputs keep their values into the next cycle.
- R8: `done` is 1 for exactly one cycle. That cycle follows the edge on which the last tuple is taken. In the same cycle `out_valid` is 0 and `cfg_ready` is 1.
- R9: The first tuple appears with `out_valid` = 1 in the cycle that follows the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Parameter set offered |
| cfg_ready | output | 1 | Block idle, parameter set can be taken |
| cfg_grp_row | input | $clog2(ARR_W) | Columns sharing one weight row (0 treated as 1) |
| cfg_grp_col | input | $clog2(ARR_W) | Column replication period (0 treated as 1) |
| cfg_row_base | input | IDX_W | Base weight row index |
| cfg_col_base | input | IDX_W | Base weight column index |
| cfg_row_stride | input | IDX_W | Column index step per PE row |
| cfg_col_stride | input | IDX_W | Column index step within one period |
| out_valid | output | 1 | Tuple available |
| out_ready | input | 1 | Consumer takes the tuple |
| out_ah | output | $clog2(ARR_H) | PE row coordinate |
| out_aw | output | $clog2(ARR_W) | PE column coordinate |
| out_row | output | IDX_W | Weight-vector row index |
| out_col | output | IDX_W | Weight-vector column index |
| done | output | 1 | One-cycle pulse after the last tuple |

## Verification
The hardest case to reach is a counter wrap that coincides with consumer stalls and with a row-end reload. For example, a group size of 3 or 5 in an 8-wide array puts the last, shorter group right against the end of the row. The bench reaches it by running non-dividing group sizes while it drops `out_ready` on a fixed cadence, so that stalls fall on wrap cycles and on row ends. In a separate run it offers a conflicting parameter set on every cycle of a walk. That run shows, through the emitted indices, that the set is ignored.

// File: rtl/pe_map_pkg.sv
package pe_map_pkg;

   typedef enum logic [0:0] {
      WRAP_STEP    = 1'b0,
      WRAP_RESTART = 1'b1
   } wrap_mode_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pe_map_wrap.sv
module pe_map_wrap
   import pe_map_pkg::*;
#(
   parameter int         CW   = 3,
   parameter int         DW   = 16,
   parameter wrap_mode_e MODE = WRAP_STEP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic [CW-1:0] lim,
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] step,
   output logic [DW-1:0] acc,
   output logic [CW-1:0] cnt
);

   logic          at_lim;
   logic [DW-1:0] acc_adv;

   assign at_lim = (cnt == CW'(lim - 1'b1));

   generate
      if (MODE == WRAP_STEP) begin : g_step
         assign acc_adv = at_lim ? acc + step : acc;
      end else begin : g_restart
         assign acc_adv = at_lim ? base : acc + step;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         acc <= '0;
      end else if (clr) begin
         cnt <= '0;
         acc <= base;
      end else if (adv) begin
         cnt <= at_lim ? '0 : cnt + 1'b1;
         acc <= acc_adv;
      end
   end

   AST_CNT_BELOW_LIM: assert property (@(posedge clk) disable iff (!rst_n)
      (lim != '0) |-> (cnt < lim)); // R4

endmodule

// File: rtl/pe_map_walk.sv
module pe_map_walk #(
   parameter int ARR_H = 4,
   parameter int ARR_W = 8,
   localparam int AHB = $clog2(ARR_H),
   localparam int AWB = $clog2(ARR_W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           adv,
   output logic           busy,
   output logic [AHB-1:0] ah,
   output logic [AWB-1:0] aw,
   output logic           row_end,
   output logic           last,
   output logic           done
);

   assign row_end = (aw == AWB'(ARR_W - 1));
   assign last    = row_end && (ah == AHB'(ARR_H - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ah   <= '0;
         aw   <= '0;
         done <= 1'b0;
      end else begin
         done <= adv && last;
         if (start) begin
            busy <= 1'b1;
            ah   <= '0;
            aw   <= '0;
         end else if (adv) begin
            if (last) busy <= 1'b0;
            if (row_end) begin
               aw <= '0;
               ah <= ah + 1'b1;
            end else begin
               aw <= aw + 1'b1;
            end
         end
      end
   end

   AST_ORDER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !row_end) |=> (aw == $past(aw) + 1'b1) && (ah == $past(ah))); // R3
   AST_ORDER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && row_end && !last) |=> (aw == '0) && (ah == $past(ah) + 1'b1)); // R3
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && last) |=> done && !busy); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

endmodule

// File: rtl/pe_map_gen.sv
module pe_map_gen
   import pe_map_pkg::*;
#(
   parameter int ARR_H = 4,
   parameter int ARR_W = 8,
   parameter int IDX_W = 16,
   localparam int AHB = $clog2(ARR_H),
   localparam int AWB = $clog2(ARR_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   output logic             cfg_ready,
   input  logic [AWB-1:0]   cfg_grp_row,
   input  logic [AWB-1:0]   cfg_grp_col,
   input  logic [IDX_W-1:0] cfg_row_base,
   input  logic [IDX_W-1:0] cfg_col_base,
   input  logic [IDX_W-1:0] cfg_row_stride,
   input  logic [IDX_W-1:0] cfg_col_stride,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [AHB-1:0]   out_ah,
   output logic [AWB-1:0]   out_aw,
   output logic [IDX_W-1:0] out_row,
   output logic [IDX_W-1:0] out_col,
   output logic             done
);

   generate
      if (!is_pow2(ARR_H) || ARR_H < 2) begin : g_bad_h
         $error("ARR_H must be a power of two of at least 2");
      end
      if (!is_pow2(ARR_W) || ARR_W < 2) begin : g_bad_w
         $error("ARR_W must be a power of two of at least 2");
      end
      if (IDX_W < 2) begin : g_bad_idx
         $error("IDX_W must be at least 2");
      end
   endgenerate

   logic             busy, accept, adv, row_end, last, clr;
   logic [AWB-1:0]   gr_q, gc_q;
   logic [IDX_W-1:0] r0_q, sr_q, sc_q, crow_q;
   logic [IDX_W-1:0] row_acc, col_acc;
   logic [AWB-1:0]   gr_cnt, gc_cnt;

   assign cfg_ready = !busy;
   assign accept    = cfg_valid && cfg_ready;
   assign adv       = busy && out_ready;
   assign clr       = accept || (adv && row_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gr_q   <= AWB'(1);
         gc_q   <= AWB'(1);
         r0_q   <= '0;
         sr_q   <= '0;
         sc_q   <= '0;
         crow_q <= '0;
      end else if (accept) begin
         gr_q   <= (cfg_grp_row == '0) ? AWB'(1) : cfg_grp_row;
         gc_q   <= (cfg_grp_col == '0) ? AWB'(1) : cfg_grp_col;
         r0_q   <= cfg_row_base;
         sr_q   <= cfg_row_stride;
         sc_q   <= cfg_col_stride;
         crow_q <= cfg_col_base;
      end else if (adv && row_end) begin
         crow_q <= crow_q + sr_q;
      end
   end

   pe_map_walk #(.ARR_H(ARR_H), .ARR_W(ARR_W)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .adv     (adv),
      .busy    (busy),
      .ah      (out_ah),
      .aw      (out_aw),
      .row_end (row_end),
      .last    (last),
      .done    (done)
   );

   pe_map_wrap #(.CW(AWB), .DW(IDX_W), .MODE(WRAP_STEP)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .adv   (adv),
      .lim   (gr_q),
      .base  (accept ? cfg_row_base : r0_q),
      .step  (IDX_W'(1)),
      .acc   (row_acc),
      .cnt   (gr_cnt)
   );

   pe_map_wrap #(.CW(AWB), .DW(IDX_W), .MODE(WRAP_RESTART)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .adv   (adv),
      .lim   (gc_q),
      .base  ('0),
      .step  (sc_q),
      .acc   (col_acc),
      .cnt   (gc_cnt)
   );

   assign out_valid = busy;
   assign out_row   = row_acc;
   assign out_col   = crow_q + col_acc;

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_ah) && $stable(out_aw)
                                    && $stable(out_row) && $stable(out_col)); // R7
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !(adv && last)) |=> $stable(gr_q) && $stable(gc_q) && $stable(sc_q)
                                        && $stable(r0_q)); // R2
   AST_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_aw == '0) |-> (out_row == r0_q) && (gr_cnt == '0) && (gc_cnt == '0)); // R4
   AST_FIRST_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid && (out_ah == '0) && (out_aw == '0)); // R9

endmodule

// File: tb/pe_map_gen_test.sv
module pe_map_gen_test;

   localparam int H  = 4;
   localparam int W  = 8;
   localparam int IW = 16;
   localparam int AHB = $clog2(H);
   localparam int AWB = $clog2(W);
   localparam int MASK = (1 << IW) - 1;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           cfg_valid;
   logic           cfg_ready;
   logic [AWB-1:0] cfg_grp_row, cfg_grp_col;
   logic [IW-1:0]  cfg_row_base, cfg_col_base, cfg_row_stride, cfg_col_stride;
   logic           out_valid, out_ready;
   logic [AHB-1:0] out_ah;
   logic [AWB-1:0] out_aw;
   logic [IW-1:0]  out_row, out_col;
   logic           done;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pe_map_gen #(.ARR_H(H), .ARR_W(W), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
      .cfg_grp_row(cfg_grp_row), .cfg_grp_col(cfg_grp_col),
      .cfg_row_base(cfg_row_base), .cfg_col_base(cfg_col_base),
      .cfg_row_stride(cfg_row_stride), .cfg_col_stride(cfg_col_stride),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_ah(out_ah), .out_aw(out_aw), .out_row(out_row), .out_col(out_col),
      .done(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cfg_valid = 1'b0; out_ready = 1'b0;
      cfg_grp_row = '0; cfg_grp_col = '0;
      cfg_row_base = '0; cfg_col_base = '0; cfg_row_stride = '0; cfg_col_stride = '0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
      check(done == 1'b0, "R1 done in reset", done, 0);
      check(cfg_ready == 1'b1, "R1 cfg_ready in reset", cfg_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && cfg_ready == 1'b1, "R1 idle after reset", out_valid, 0);
   endtask

   task automatic run_map(input int gr, input int gc, input int r0, input int c0,
                          input int sr, input int sc, input int stall_mod, input bit poke);
      int idx = 0;
      int cyc = 0;
      int ge = (gr == 0) ? 1 : gr;
      int ce = (gc == 0) ? 1 : gc;
      bit stalled = 1'b0;
      int prow = 0;
      int pcol = 0;
      @(negedge clk);
      check(cfg_ready == 1'b1, "R2 ready when idle", cfg_ready, 1);
      cfg_grp_row = AWB'(gr); cfg_grp_col = AWB'(gc);
      cfg_row_base = IW'(r0); cfg_col_base = IW'(c0);
      cfg_row_stride = IW'(sr); cfg_col_stride = IW'(sc);
      cfg_valid = 1'b1;
      out_ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cfg_valid = 1'b0;
      check(out_valid == 1'b1, "R9 first tuple after accept", out_valid, 1);
      while (idx < H * W && cyc < 4000) begin
         int eah = idx / W;
         int eaw = idx % W;
         int erow = (r0 + eaw / ge) & MASK;
         int ecol = (c0 + sr * eah + sc * (eaw % ce)) & MASK;
         out_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
         if (poke) begin
            cfg_valid = 1'b1;
            cfg_grp_row = AWB'(cyc + 1); cfg_grp_col = AWB'(cyc + 2);
            cfg_row_base = IW'(cyc * 77); cfg_col_base = IW'(cyc * 13);
            cfg_row_stride = IW'(cyc); cfg_col_stride = IW'(cyc + 9);
         end
         check(out_valid == 1'b1, "R3 valid during walk", out_valid, 1);
         check(cfg_ready == 1'b0, "R2 busy during walk", cfg_ready, 0);
         check(int'(out_ah) == eah && int'(out_aw) == eaw, "R3 order aw", int'(out_aw), eaw);
         check(int'(out_row) == erow, "R4 row index", int'(out_row), erow);
         check(int'(out_col) == ecol, "R5 col index", int'(out_col), ecol);
         if (stalled) begin
            check(int'(out_row) == prow && int'(out_col) == pcol, "R7 held under stall",
                  int'(out_col), pcol);
         end
         stalled = !out_ready;
         prow = int'(out_row);
         pcol = int'(out_col);
         @(posedge clk);
         if (out_ready) idx++;
         cyc++;
         @(negedge clk);
      end
      cfg_valid = 1'b0;
      out_ready = 1'b0;
      check(idx == H * W, "R3 tuple count", idx, H * W);
      check(done == 1'b1, "R8 done after last", done, 1);
      check(out_valid == 1'b0 && cfg_ready == 1'b1, "R8 idle with done", out_valid, 0);
      @(negedge clk);
      check(done == 1'b0, "R8 done single cycle", done, 0);
      check(out_valid == 1'b0, "R2 no restart from ignored cfg", out_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      run_map(2, 4, 10, 100, 3, 5, 0, 1'b0);           // R4 R5 dividing groups
      run_map(3, 5, 7, 20, 40, 2, 3, 1'b0);            // R4 R5 R7 non-dividing with stalls
      run_map(0, 0, 1, 2, 6, 11, 0, 1'b0);             // R6 zero groups as one
      run_map(1, 1, 1, 2, 6, 11, 2, 1'b0);             // R6 reference with one
      run_map(7, 3, 5, 9, 1, 4, 4, 1'b1);              // R2 cfg ignored while busy
      run_map(4, 6, 65534, 65530, 700, 1000, 0, 1'b0); // R4 R5 modular wrap
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule